// File: doc/BRIEF.md
# Message-Signaled Interrupt Capability and Message Generator

This block keeps the message-signaled-interrupt capability registers of one function and converts internal interrupt events into single DWORD memory-write requests. Configuration software reaches the capability through a DWORD-wide register port. The block offers the layout with a 64-bit message address and per-vector masking: a header word, a low and a high address word, a data word, a mask word and a pending word.

Each event input is a level. Its rising edge asks for a message on the vector that the input maps to. The allocated vector count is a power of two, chosen by software at or below the count the block advertises. The vector number replaces as many low bits of the message data as the count needs. A masked vector collects its event as a pending bit and sends it later, when it is unmasked. A lowest-index-first arbiter issues one request at a time on a valid/ready handshake. When message signalling and its table-based sibling are both off, a legacy active-low interrupt pin reports the OR of the event levels.

Top module: `msi_cap_gen`

## Requirements
- R1: After reset the enable bit, the allocation field, all mask bits and all pending bits are zero, no request is valid, and DWORD 0 reads capability ID 05h in bits 7:0 and NEXT_PTR in bits 15:8.
- R2: The register index on cfg_addr selects the word: 0 header, 1 address low, 2 address high, 3 data, 4 mask, 5 pending; indexes 6 and 7 read zero. The control half (bits 31:16 of word 0) holds the enable in bit 16, the advertised count CAP_LOG2 in bits 19:17 (read-only), the allocation field in bits 22:20, and ones in bits 23 and 24; all other control bits read zero. Word 3 keeps only its low 16 bits.
- R3: A write of 6 or 7 to the allocation field leaves it unchanged. A write of a value above CAP_LOG2 stores CAP_LOG2.
- R4: Address bits 1:0 always read and send as zero. A request carries {high word, low word} as its address, and req_wide_o is 1 exactly when the high word is nonzero.
- R5: With allocation field k, the request data is {16'h0, message data with its low k bits replaced by the vector number}. With k = 0 the data is sent unchanged.
- R6: A message is triggered by the rising edge of an event input. Input i maps to vector i mod 2^k.
- R7: A trigger on a masked vector sets its pending bit and sends nothing. Once the vector is unmasked the message is sent. A pending bit stays set from the trigger until the request is accepted.
- R8: A pending bit on a masked vector clears when every input that maps to that vector is low. A new rising edge sets it again.
- R9: At most one request is in flight. The eligible vector with the lowest index goes first. A valid request keeps its address and data stable until req_ready_i, and req_valid_o drops in the cycle after acceptance.
- R10: Requests are issued and triggers are recorded only while the enable bit is 1 and msix_en_i is 0. irq_pin_n_o is low exactly when some event is high and both the enable bit and msix_en_i are 0.
- R11: The pending word is read-only. Mask and pending bits at or above 2^CAP_LOG2 read zero and cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | DWORD register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| msix_en_i | input | 1 | Table-based interrupt mode is enabled elsewhere |
| evt_i | input | NUM_EVT | Interrupt event levels |
| req_valid_o | output | 1 | Memory-write request valid |
| req_ready_i | input | 1 | Request accepted |
| req_addr_o | output | 64 | Request address |
| req_data_o | output | 32 | Request DWORD data |
| req_wide_o | output | 1 | Upper address half is nonzero |
| irq_pin_n_o | output | 1 | Legacy active-low interrupt pin |

## Verification
The bench builds the block with NUM_EVT = 12, CAP_LOG2 = 3 and NEXT_PTR = 40h. Twelve inputs over at most eight vectors make aliasing happen at every allocation size. Allocation requests of 4 and 5 exceed the advertised count, so the clamp can be exercised. The implemented mask is eight bits wide, so the reserved upper mask and pending bits can be exercised as well. Runs at allocation sizes 1, 4 and 8 cover the data substitution for zero, two and three replaced bits.

// File: rtl/msi_cap_pkg.sv
`timescale 1ns/1ps
package msi_cap_pkg;

   localparam logic [7:0] MSI_CAP_ID = 8'h05;
   localparam int         MAX_LOG2   = 5;

   typedef enum logic [2:0] {
      REG_HDR     = 3'd0,
      REG_ADDR_LO = 3'd1,
      REG_ADDR_HI = 3'd2,
      REG_DATA    = 3'd3,
      REG_MASK    = 3'd4,
      REG_PEND    = 3'd5
   } msi_reg_e;

   // reserved encodings keep the old value, oversize ones saturate
   function automatic logic [2:0] clamp_alloc(input logic [2:0] wr,
                                              input logic [2:0] cur,
                                              input logic [2:0] cap);
      if (wr > 3'd5)     return cur;
      else if (wr > cap) return cap;
      else               return wr;
   endfunction

endpackage

// File: rtl/msi_cap_regs.sv
`timescale 1ns/1ps
module msi_cap_regs
   import msi_cap_pkg::*;
#(
   parameter int          CAP_LOG2 = 5,
   parameter logic [7:0]  NEXT_PTR = 8'h00,
   parameter int          VEC_MAX  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_addr,
   input  logic [31:0]        cfg_wdata,
   output logic [31:0]        cfg_rdata,
   input  logic [VEC_MAX-1:0] pend_i,
   output logic               en_o,
   output logic [2:0]         mme_o,
   output logic [VEC_MAX-1:0] mask_o,
   output logic [31:0]        addr_lo_o,
   output logic [31:0]        addr_hi_o,
   output logic [15:0]        data_o
);

   localparam logic [2:0] CAP_ENC = 3'(CAP_LOG2);

   logic               en_q;
   logic [2:0]         mme_q;
   logic [31:2]        lo_q;
   logic [31:0]        hi_q;
   logic [15:0]        data_q;
   logic [VEC_MAX-1:0] mask_q;
   logic [15:0]        ctrl_w;
   logic [31:0]        mask_w;
   logic [31:0]        pend_w;
   logic               unused_wdata;

   assign unused_wdata = ^cfg_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mme_q  <= 3'd0;
         lo_q   <= '0;
         hi_q   <= '0;
         data_q <= '0;
         mask_q <= '0;
      end else if (cfg_we) begin
         case (msi_reg_e'(cfg_addr))
            REG_HDR: begin
               en_q  <= cfg_wdata[16];
               mme_q <= clamp_alloc(cfg_wdata[22:20], mme_q, CAP_ENC);
            end
            REG_ADDR_LO: lo_q   <= cfg_wdata[31:2];
            REG_ADDR_HI: hi_q   <= cfg_wdata;
            REG_DATA:    data_q <= cfg_wdata[15:0];
            REG_MASK:    mask_q <= cfg_wdata[VEC_MAX-1:0];
            default: ;
         endcase
      end
   end

   assign ctrl_w = {7'b0, 1'b1, 1'b1, mme_q, CAP_ENC, en_q};

   always_comb begin
      mask_w = '0;
      pend_w = '0;
      mask_w[VEC_MAX-1:0] = mask_q;
      pend_w[VEC_MAX-1:0] = pend_i;
   end

   always_comb begin
      case (msi_reg_e'(cfg_addr))
         REG_HDR:     cfg_rdata = {ctrl_w, NEXT_PTR, MSI_CAP_ID};
         REG_ADDR_LO: cfg_rdata = {lo_q, 2'b00};
         REG_ADDR_HI: cfg_rdata = hi_q;
         REG_DATA:    cfg_rdata = {16'h0000, data_q};
         REG_MASK:    cfg_rdata = mask_w;
         REG_PEND:    cfg_rdata = pend_w;
         default:     cfg_rdata = '0;
      endcase
   end

   assign en_o      = en_q;
   assign mme_o     = mme_q;
   assign mask_o    = mask_q;
   assign addr_lo_o = {lo_q, 2'b00};
   assign addr_hi_o = hi_q;
   assign data_o    = data_q;

   // R3: the allocation never exceeds the advertised count
   p_alloc_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mme_q <= CAP_ENC);

endmodule

// File: rtl/msi_vec_state.sv
`timescale 1ns/1ps
module msi_vec_state #(
   parameter int NUM_EVT = 32,
   parameter int VEC_MAX = 32,
   parameter int VEC_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               active_i,
   input  logic [2:0]         mme_i,
   input  logic [VEC_MAX-1:0] mask_i,
   input  logic               acc_i,
   input  logic [VEC_W-1:0]   acc_vec_i,
   output logic [VEC_MAX-1:0] flag_o
);

   logic [NUM_EVT-1:0] evt_q;
   logic [NUM_EVT-1:0] rise;
   logic [VEC_MAX-1:0] trig;
   logic [VEC_MAX-1:0] lvl;
   logic [5:0]         cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) evt_q <= '0;
      else        evt_q <= evt_i;
   end

   assign rise = evt_i & ~evt_q;
   assign cnt  = 6'd1 << mme_i;

   // fold inputs onto vectors: input i drives vector i mod count
   always_comb begin
      trig = '0;
      lvl  = '0;
      for (int v = 0; v < VEC_MAX; v++) begin
         for (int i = 0; i < NUM_EVT; i++) begin
            if ((i & (int'(cnt) - 1)) == v) begin
               trig[v] = trig[v] | rise[i];
               lvl[v]  = lvl[v]  | evt_i[i];
            end
         end
      end
   end

   for (genvar gv = 0; gv < VEC_MAX; gv++) begin : g_vec
      logic flag_q;
      logic hit_acc;

      assign hit_acc = acc_i && (int'(acc_vec_i) == gv);

      always_ff @(posedge clk) begin
         if (!rst_n)                        flag_q <= 1'b0;
         else if (active_i && trig[gv])     flag_q <= 1'b1;
         else if (hit_acc)                  flag_q <= 1'b0;
         else if (mask_i[gv] && !lvl[gv])   flag_q <= 1'b0;
      end

      assign flag_o[gv] = flag_q;

      // R7: a recorded trigger is never lost in the cycle it arrives
      p_pend_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
         active_i && trig[gv] |=> flag_q);
   end

endmodule

// File: rtl/msi_msg_arb.sv
`timescale 1ns/1ps
module msi_msg_arb #(
   parameter int VEC_MAX = 32,
   parameter int VEC_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active_i,
   input  logic [VEC_MAX-1:0] flag_i,
   input  logic [VEC_MAX-1:0] mask_i,
   input  logic [2:0]         mme_i,
   input  logic [31:0]        addr_lo_i,
   input  logic [31:0]        addr_hi_i,
   input  logic [15:0]        data_i,
   input  logic               req_ready_i,
   output logic               req_valid_o,
   output logic [63:0]        req_addr_o,
   output logic [31:0]        req_data_o,
   output logic               req_wide_o,
   output logic               acc_o,
   output logic [VEC_W-1:0]   acc_vec_o
);

   logic [VEC_MAX-1:0] elig;
   logic               any;
   logic [VEC_W-1:0]   pick;
   logic [15:0]        vmask;
   logic [15:0]        msg;

   logic               valid_q;
   logic [VEC_W-1:0]   vec_q;
   logic [63:0]        addr_q;
   logic [31:0]        data_q;
   logic               wide_q;

   always_comb begin
      elig = '0;
      for (int v = 0; v < VEC_MAX; v++)
         elig[v] = flag_i[v] && !mask_i[v] && (v < (32'sd1 <<< mme_i));
   end

   // scan downward so the lowest index is the last one written
   always_comb begin
      any  = 1'b0;
      pick = '0;
      for (int v = VEC_MAX - 1; v >= 0; v--) begin
         if (elig[v]) begin
            any  = 1'b1;
            pick = VEC_W'(v);
         end
      end
   end

   assign vmask = (16'd1 << mme_i) - 16'd1;
   assign msg   = (data_i & ~vmask) | (16'(pick) & vmask);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         vec_q   <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         wide_q  <= 1'b0;
      end else if (valid_q && req_ready_i) begin
         valid_q <= 1'b0;
      end else if (!valid_q && active_i && any) begin
         valid_q <= 1'b1;
         vec_q   <= pick;
         addr_q  <= {addr_hi_i, addr_lo_i};
         data_q  <= {16'h0000, msg};
         wide_q  <= (addr_hi_i != 32'd0);
      end
   end

   assign req_valid_o = valid_q;
   assign req_addr_o  = addr_q;
   assign req_data_o  = data_q;
   assign req_wide_o  = wide_q;
   assign acc_o       = valid_q && req_ready_i;
   assign acc_vec_o   = vec_q;

   // R9: a stalled request keeps its content
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o && !req_ready_i |=>
         req_valid_o && $stable(req_addr_o) && $stable(req_data_o));

endmodule

// File: rtl/msi_cap_gen.sv
`timescale 1ns/1ps
module msi_cap_gen #(
   parameter int         NUM_EVT  = 32,
   parameter int         CAP_LOG2 = 5,
   parameter logic [7:0] NEXT_PTR = 8'h00
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_addr,
   input  logic [31:0]        cfg_wdata,
   output logic [31:0]        cfg_rdata,
   input  logic               msix_en_i,
   input  logic [NUM_EVT-1:0] evt_i,
   output logic               req_valid_o,
   input  logic               req_ready_i,
   output logic [63:0]        req_addr_o,
   output logic [31:0]        req_data_o,
   output logic               req_wide_o,
   output logic               irq_pin_n_o
);

   localparam int VEC_MAX = 1 << CAP_LOG2;
   localparam int VEC_W   = (CAP_LOG2 == 0) ? 1 : CAP_LOG2;

   if (CAP_LOG2 < 0 || CAP_LOG2 > msi_cap_pkg::MAX_LOG2) begin : g_bad_cap
      $error("CAP_LOG2 must lie in 0..5");
   end
   if (NUM_EVT < 1 || NUM_EVT > 32) begin : g_bad_evt
      $error("NUM_EVT must lie in 1..32");
   end

   logic               en;
   logic [2:0]         mme;
   logic [VEC_MAX-1:0] mask;
   logic [VEC_MAX-1:0] flag;
   logic [31:0]        addr_lo;
   logic [31:0]        addr_hi;
   logic [15:0]        data;
   logic               msi_active;
   logic               acc;
   logic [VEC_W-1:0]   acc_vec;

   assign msi_active = en && !msix_en_i;

   msi_cap_regs #(
      .CAP_LOG2 (CAP_LOG2),
      .NEXT_PTR (NEXT_PTR),
      .VEC_MAX  (VEC_MAX)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .pend_i    (flag),
      .en_o      (en),
      .mme_o     (mme),
      .mask_o    (mask),
      .addr_lo_o (addr_lo),
      .addr_hi_o (addr_hi),
      .data_o    (data)
   );

   msi_vec_state #(
      .NUM_EVT (NUM_EVT),
      .VEC_MAX (VEC_MAX),
      .VEC_W   (VEC_W)
   ) u_vec (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt_i),
      .active_i  (msi_active),
      .mme_i     (mme),
      .mask_i    (mask),
      .acc_i     (acc),
      .acc_vec_i (acc_vec),
      .flag_o    (flag)
   );

   msi_msg_arb #(
      .VEC_MAX (VEC_MAX),
      .VEC_W   (VEC_W)
   ) u_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .active_i    (msi_active),
      .flag_i      (flag),
      .mask_i      (mask),
      .mme_i       (mme),
      .addr_lo_i   (addr_lo),
      .addr_hi_i   (addr_hi),
      .data_i      (data),
      .req_ready_i (req_ready_i),
      .req_valid_o (req_valid_o),
      .req_addr_o  (req_addr_o),
      .req_data_o  (req_data_o),
      .req_wide_o  (req_wide_o),
      .acc_o       (acc),
      .acc_vec_o   (acc_vec)
   );

   assign irq_pin_n_o = !((|evt_i) && !en && !msix_en_i);

   // R10: a request only starts while message signalling is active
   p_no_send_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid_o) |-> $past(msi_active));

   // R9: one request in flight, released the cycle after acceptance
   p_single_flight_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o && req_ready_i |=> !req_valid_o);

endmodule

// File: tb/msi_cap_gen_bench.sv
`timescale 1ns/1ps
module msi_cap_gen_bench;

   localparam int         NEVT = 12;
   localparam int         CAPL = 3;
   localparam int         NV   = 8;
   localparam logic [7:0] NXT  = 8'h40;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [2:0]      cfg_addr = 3'd0;
   logic [31:0]     cfg_wdata = '0;
   logic [31:0]     cfg_rdata;
   logic            msix = 1'b0;
   logic [NEVT-1:0] evt = '0;
   logic            req_valid;
   logic            req_ready = 1'b1;
   logic [63:0]     req_addr;
   logic [31:0]     req_data;
   logic            req_wide;
   logic            irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   msi_cap_gen #(.NUM_EVT(NEVT), .CAP_LOG2(CAPL), .NEXT_PTR(NXT)) u_msi_cap_gen (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .msix_en_i(msix),
      .evt_i(evt), .req_valid_o(req_valid), .req_ready_i(req_ready),
      .req_addr_o(req_addr), .req_data_o(req_data), .req_wide_o(req_wide),
      .irq_pin_n_o(irq_n));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   bit          m_en;
   int          m_mme;
   bit [NV-1:0] m_mask;
   bit [31:0]   m_lo, m_hi;
   bit [15:0]   m_data;
   bit [NV-1:0] m_flag;
   bit [NEVT-1:0] m_prev;
   bit          m_valid;
   int          m_vec;
   bit [63:0]   m_addr;
   bit [31:0]   m_dat;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_mme = 0; m_mask = '0; m_lo = '0; m_hi = '0; m_data = '0;
         m_flag = '0; m_prev = '0; m_valid = 0; m_vec = 0; m_addr = '0; m_dat = '0;
      end else begin
         bit act, acc;
         int cnt, launch, w;
         bit [NV-1:0] trig, lvl, nf;
         act = m_en && !msix;
         cnt = 1 << m_mme;
         trig = '0; lvl = '0;
         for (int i = 0; i < NEVT; i++) begin
            if (evt[i] && !m_prev[i]) trig[i % cnt] = 1;
            if (evt[i]) lvl[i % cnt] = 1;
         end
         acc = m_valid && req_ready;
         launch = -1;
         if (!m_valid && act)
            for (int v = 0; v < NV; v++)
               if (launch < 0 && m_flag[v] && !m_mask[v] && v < cnt) launch = v;
         for (int v = 0; v < NV; v++) begin
            if (act && trig[v])             nf[v] = 1;
            else if (acc && m_vec == v)     nf[v] = 0;
            else if (m_mask[v] && !lvl[v])  nf[v] = 0;
            else                            nf[v] = m_flag[v];
         end
         if (acc) m_valid = 0;
         if (launch >= 0) begin
            m_valid = 1;
            m_vec   = launch;
            m_addr  = {m_hi, m_lo};
            m_dat   = {16'h0, (m_data & ~16'(cnt - 1)) | (16'(launch) & 16'(cnt - 1))};
         end
         m_flag = nf;
         m_prev = evt;
         if (cfg_we) begin
            case (cfg_addr)
               3'd0: begin
                  m_en = cfg_wdata[16];
                  w = int'(cfg_wdata[22:20]);
                  if (w <= 5) m_mme = (w > CAPL) ? CAPL : w;
               end
               3'd1: m_lo = {cfg_wdata[31:2], 2'b00};
               3'd2: m_hi = cfg_wdata;
               3'd3: m_data = cfg_wdata[15:0];
               3'd4: m_mask = cfg_wdata[NV-1:0];
               default: ;
            endcase
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R9 req_valid", 64'(req_valid), 64'(m_valid));
         if (m_valid) begin
            chk("R4 req_addr", req_addr, m_addr);
            chk("R5 R6 req_data", 64'(req_data), 64'(m_dat));
            chk("R4 req_wide", 64'(req_wide), 64'(m_addr[63:32] != 0));
         end
         chk("R10 irq_pin_n", 64'(irq_n), 64'(!((|evt) && !m_en && !msix)));
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); #1;
      cfg_addr = a;
      #0.5;
      chk(tag, 64'(cfg_rdata), 64'(exp));
   endtask

   task automatic set_evt(input logic [NEVT-1:0] v);
      @(negedge clk); #1;
      evt = v;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      #1 rst_n = 1'b1;

      // R1 / R2: reset image and layout
      rd(3'd0, 32'h0186_4005, "R1 header after reset");
      rd(3'd4, 32'h0, "R1 mask after reset");
      rd(3'd5, 32'h0, "R1 pending after reset");
      chk("R1 no request after reset", 64'(req_valid), 64'd0);
      rd(3'd6, 32'h0, "R2 unused index");
      wr(3'd1, 32'hFEE0_0003);
      rd(3'd1, 32'hFEE0_0000, "R4 address low bits");
      wr(3'd2, 32'h0);
      wr(3'd3, 32'hFFFF_4A2C);
      rd(3'd3, 32'h0000_4A2C, "R2 data width");

      // R3: reserved and oversize allocations
      wr(3'd0, 32'h0070_0000);
      rd(3'd0, 32'h0186_4005, "R3 reserved encoding ignored");
      wr(3'd0, 32'h0050_0000);
      rd(3'd0, 32'h01B6_4005, "R3 oversize clamped");
      wr(3'd0, 32'h0021_0000);
      rd(3'd0, 32'h01A7_4005, "R2 enable and count four");

      // R6: single event and aliasing
      set_evt(12'h002); idle(6); set_evt(12'h000); idle(3);
      set_evt(12'h040); idle(6); set_evt(12'h000); idle(3);

      // R9: ordering and hold under back-pressure
      @(negedge clk); #1 req_ready = 1'b0;
      set_evt(12'h009); idle(5);
      chk("R9 lowest index first", 64'(req_data[1:0]), 64'd0);
      idle(3);
      @(negedge clk); #1 req_ready = 1'b1;
      idle(8); set_evt(12'h000); idle(3);

      // R7: masked trigger becomes pending, sent on unmask
      wr(3'd4, 32'h1);
      set_evt(12'h001); idle(4);
      rd(3'd5, 32'h1, "R7 pending set while masked");
      chk("R7 no send while masked", 64'(req_valid), 64'd0);
      wr(3'd4, 32'h0); idle(6);
      rd(3'd5, 32'h0, "R7 pending cleared after send");
      set_evt(12'h000); idle(3);

      // R8: withdrawal of a masked pending event
      wr(3'd4, 32'h2);
      set_evt(12'h020); idle(3);
      rd(3'd5, 32'h2, "R8 pending via aliased input");
      set_evt(12'h000); idle(2);
      rd(3'd5, 32'h0, "R8 pending withdrawn");
      set_evt(12'h020); idle(2);
      rd(3'd5, 32'h2, "R8 pending set again");
      set_evt(12'h000); idle(2);
      wr(3'd4, 32'h0); idle(4);

      // R4: nonzero upper address
      wr(3'd2, 32'h0000_0001);
      set_evt(12'h800); idle(6); set_evt(12'h000); idle(3);
      wr(3'd2, 32'h0);

      // R10: gating by the other mode and legacy pin
      @(negedge clk); #1 msix = 1'b1;
      set_evt(12'h004); idle(4);
      chk("R10 no send with other mode on", 64'(req_valid), 64'd0);
      rd(3'd5, 32'h0, "R10 trigger dropped");
      set_evt(12'h000);
      @(negedge clk); #1 msix = 1'b0;
      idle(3);
      chk("R10 still no send", 64'(req_valid), 64'd0);
      wr(3'd0, 32'h0);
      set_evt(12'h001); idle(1);
      chk("R10 legacy pin low", 64'(irq_n), 64'd0);
      set_evt(12'h000); idle(1);
      chk("R10 legacy pin released", 64'(irq_n), 64'd1);

      // R11: reserved mask bits and read-only pending
      wr(3'd4, 32'hFFFF_FFFF);
      rd(3'd4, 32'h0000_00FF, "R11 reserved mask bits");
      wr(3'd5, 32'hFFFF_FFFF);
      rd(3'd5, 32'h0, "R11 pending read-only");
      wr(3'd4, 32'h0);

      // R5: single vector leaves data unchanged; eight vectors replace three bits
      wr(3'd0, 32'h0001_0000);
      set_evt(12'h080); idle(6); set_evt(12'h000); idle(3);
      wr(3'd0, 32'h0031_0000);
      set_evt(12'h100); idle(6); set_evt(12'h080); idle(6);
      set_evt(12'h000); idle(4);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule